// File: doc/BRIEF.md
# Unified Address Aperture Translator

This block turns a 64-bit flat pointer into a translation request. The request has one ATC select bit and a 48-bit virtual address. Two programmable windows are checked against the pointer. The device-VM window lets a region of the 64-bit space, which may sit inside the non-canonical hole, reach the device page tables. Its base is subtracted and the request leaves with ATC=0. The spare window changes only the memory-type code. Pointers that hit neither window go to the default space, and a mode input selects which translation path that is.

Each access carries a byte count, given as the length minus one. The block classifies the first and the last byte in parallel. It raises a violation flag when either byte lies in the unmapped hole, when the two bytes land in different regions, when the last-byte sum runs past the top of the 64-bit space, or when a device-VM offset does not fit in 40 bits. When the flag is set, the ATC bit and the address carry no meaning and must not be issued. One registered stage with a valid/ready handshake holds the result.

Top module: `flat_ptr_xlate`

## Requirements
- R1: A window register holds address bits [63:16]. The effective lower bound is that value followed by sixteen 0 bits, and the effective upper bound is that value followed by sixteen 1 bits. Both bounds count as inside the window, and the address one below or one above lies outside.
- R2: A pointer whose bits [63:47] are neither all 0 nor all 1, and that is not inside an enabled device-VM window, is in the hole and sets out_viol=1. A canonical pointer in either half is legal.
- R3: A pointer inside the device-VM window gives out_atc=0, out_addr equal to the low 48 bits of pointer minus effective base, and out_mtype=mt_dvm.
- R4: A legal pointer outside both windows gives out_addr equal to pointer bits [47:0] and out_mtype=mt_dflt. It gives out_atc=1 when mode_host_dflt=1 and out_atc=0 when mode_host_dflt=0.
- R5: A pointer inside the spare window gives out_mtype=mt_spare and out_addr equal to pointer bits [47:0], with out_atc set by mode_host_dflt as in R4.
- R6: The last byte address is pointer plus in_cnt (in_cnt = byte length minus one). If the first and last bytes fall in different regions, or if that sum carries out of bit 63, then out_viol=1.
- R7: A device-VM hit whose offset from the effective base is 2^40 or more sets out_viol=1. An offset of 2^40-1 is legal.
- R8: A window whose enable input is 0 matches no address.
- R9: in_ready is high when out_valid is low or out_ready is high. An accepted request appears on the outputs at the next clock edge. While out_valid=1 and out_ready=0, all outputs hold their values.
- R10: During reset and right after it, out_valid=0 and in_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high with in_valid |
| in_ptr | input | 64 | Flat pointer to the first byte |
| in_cnt | input | 8 | Payload byte length minus one |
| mode_host_dflt | input | 1 | 1: unmatched addresses use ATC=1; 0: they use ATC=0 |
| dvm_en | input | 1 | Device-VM window enable |
| dvm_base_hi | input | 48 | Device-VM window lower bound, bits [63:16] |
| dvm_limit_hi | input | 48 | Device-VM window upper bound, bits [63:16] |
| spare_en | input | 1 | Spare window enable |
| spare_base_hi | input | 48 | Spare window lower bound, bits [63:16] |
| spare_limit_hi | input | 48 | Spare window upper bound, bits [63:16] |
| mt_dflt | input | 2 | Memory type for the default space |
| mt_dvm | input | 2 | Memory type for device-VM hits |
| mt_spare | input | 2 | Memory type for spare hits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_atc | output | 1 | Translation path select |
| out_addr | output | 48 | Translated virtual address |
| out_mtype | output | 2 | Memory-type code |
| out_viol | output | 1 | Memory violation; the request must not be issued |

## Verification
The classification state is the region code of each byte. A wrong code shows at the ports one cycle after acceptance, as a wrong memory type, a wrong ATC bit, an address missing the base subtraction, or a missing or spurious violation. The tests therefore place pointers exactly on each bound and one step outside it, and run the same pointer under both modes. A fault in the output register shows in the stall cycles, as a result that changes or is dropped while out_ready is low.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [1:0] {
    RG_DFLT  = 2'd0,
    RG_DVM   = 2'd1,
    RG_SPARE = 2'd2,
    RG_HOLE  = 2'd3
  } region_e;
endpackage

// File: rtl/fpx_classify.sv
module fpx_classify #(
  parameter int PTR_W  = 64,
  parameter int OUT_W  = 48,
  parameter int GRAN_W = 16
) (
  input  logic [PTR_W-1:0]        addr,
  input  logic                    dvm_en,
  input  logic [PTR_W-GRAN_W-1:0] dvm_base_hi,
  input  logic [PTR_W-GRAN_W-1:0] dvm_limit_hi,
  input  logic                    spare_en,
  input  logic [PTR_W-GRAN_W-1:0] spare_base_hi,
  input  logic [PTR_W-GRAN_W-1:0] spare_limit_hi,
  output fpx_pkg::region_e        region
);
  localparam int HI_W  = PTR_W - GRAN_W;
  localparam int TOP_W = PTR_W - OUT_W + 1;

  function automatic logic [PTR_W-1:0] lo_edge(input logic [HI_W-1:0] hi);
    return {hi, {GRAN_W{1'b0}}};
  endfunction

  function automatic logic [PTR_W-1:0] hi_edge(input logic [HI_W-1:0] hi);
    return {hi, {GRAN_W{1'b1}}};
  endfunction

  function automatic logic in_window(input logic [PTR_W-1:0] a,
                                     input logic [HI_W-1:0] b,
                                     input logic [HI_W-1:0] l);
    return (a >= lo_edge(b)) && (a <= hi_edge(l));
  endfunction

  logic [TOP_W-1:0] top_bits;
  logic canonical, dvm_hit, spare_hit;

  assign top_bits  = addr[PTR_W-1:OUT_W-1];
  assign canonical = (top_bits == '0) || (&top_bits);
  assign dvm_hit   = dvm_en && in_window(addr, dvm_base_hi, dvm_limit_hi);
  assign spare_hit = spare_en && in_window(addr, spare_base_hi, spare_limit_hi);

  always_comb begin
    if (dvm_hit)         region = fpx_pkg::RG_DVM;
    else if (!canonical) region = fpx_pkg::RG_HOLE;
    else if (spare_hit)  region = fpx_pkg::RG_SPARE;
    else                 region = fpx_pkg::RG_DFLT;
  end
endmodule

// File: rtl/fpx_resolve.sv
module fpx_resolve #(
  parameter int PTR_W  = 64,
  parameter int OUT_W  = 48,
  parameter int GRAN_W = 16,
  parameter int DVM_W  = 40,
  parameter int MT_W   = 2
) (
  input  logic [PTR_W-1:0]        ptr,
  input  fpx_pkg::region_e        rgn_first,
  input  fpx_pkg::region_e        rgn_last,
  input  logic                    wrap,
  input  logic                    mode_host_dflt,
  input  logic [PTR_W-GRAN_W-1:0] dvm_base_hi,
  input  logic [MT_W-1:0]         mt_dflt,
  input  logic [MT_W-1:0]         mt_dvm,
  input  logic [MT_W-1:0]         mt_spare,
  output logic                    atc,
  output logic [OUT_W-1:0]        addr,
  output logic [MT_W-1:0]         mtype,
  output logic                    viol
);
  function automatic logic [PTR_W-1:0] dvm_offset(input logic [PTR_W-1:0] p,
                                                  input logic [PTR_W-GRAN_W-1:0] b);
    return p - {b, {GRAN_W{1'b0}}};
  endfunction

  logic [PTR_W-1:0] off;
  logic off_big;

  assign off     = dvm_offset(ptr, dvm_base_hi);
  assign off_big = |off[PTR_W-1:DVM_W];

  always_comb begin
    viol = (rgn_first == fpx_pkg::RG_HOLE) || (rgn_last == fpx_pkg::RG_HOLE) ||
           (rgn_first != rgn_last) || wrap ||
           ((rgn_first == fpx_pkg::RG_DVM) && off_big);
    atc   = mode_host_dflt;
    addr  = ptr[OUT_W-1:0];
    mtype = mt_dflt;
    case (rgn_first)
      fpx_pkg::RG_DVM: begin
        atc   = 1'b0;
        addr  = off[OUT_W-1:0];
        mtype = mt_dvm;
      end
      fpx_pkg::RG_SPARE: mtype = mt_spare;
      default: ;
    endcase
  end
endmodule

// File: rtl/fpx_stage.sv
module fpx_stage #(
  parameter int OUT_W = 48,
  parameter int MT_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             d_atc,
  input  logic [OUT_W-1:0] d_addr,
  input  logic [MT_W-1:0]  d_mtype,
  input  logic             d_viol,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             q_atc,
  output logic [OUT_W-1:0] q_addr,
  output logic [MT_W-1:0]  q_mtype,
  output logic             q_viol
);
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q_atc     <= 1'b0;
      q_addr    <= '0;
      q_mtype   <= '0;
      q_viol    <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        q_atc     <= d_atc;
        q_addr    <= d_addr;
        q_mtype   <= d_mtype;
        q_viol    <= d_viol;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flat_ptr_xlate.sv
module flat_ptr_xlate #(
  parameter int PTR_W  = 64,
  parameter int OUT_W  = 48,
  parameter int GRAN_W = 16,
  parameter int DVM_W  = 40,
  parameter int CNT_W  = 8,
  parameter int MT_W   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [PTR_W-1:0]        in_ptr,
  input  logic [CNT_W-1:0]        in_cnt,
  input  logic                    mode_host_dflt,
  input  logic                    dvm_en,
  input  logic [PTR_W-GRAN_W-1:0] dvm_base_hi,
  input  logic [PTR_W-GRAN_W-1:0] dvm_limit_hi,
  input  logic                    spare_en,
  input  logic [PTR_W-GRAN_W-1:0] spare_base_hi,
  input  logic [PTR_W-GRAN_W-1:0] spare_limit_hi,
  input  logic [MT_W-1:0]         mt_dflt,
  input  logic [MT_W-1:0]         mt_dvm,
  input  logic [MT_W-1:0]         mt_spare,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_atc,
  output logic [OUT_W-1:0]        out_addr,
  output logic [MT_W-1:0]         out_mtype,
  output logic                    out_viol
);
  localparam int NPROBE = 2;

  logic [PTR_W-1:0] last_ptr;
  logic             wrap;
  logic [PTR_W-1:0] probe [NPROBE];
  fpx_pkg::region_e rgn [NPROBE];
  fpx_pkg::region_e rgn_first, rgn_last;

  assign {wrap, last_ptr} = {1'b0, in_ptr} + (PTR_W+1)'(in_cnt);
  assign probe[0]  = in_ptr;
  assign probe[1]  = last_ptr;
  assign rgn_first = rgn[0];
  assign rgn_last  = rgn[1];

  for (genvar g = 0; g < NPROBE; g++) begin : g_probe
    fpx_classify #(.PTR_W(PTR_W), .OUT_W(OUT_W), .GRAN_W(GRAN_W)) u_cls (
      .addr          (probe[g]),
      .dvm_en        (dvm_en),
      .dvm_base_hi   (dvm_base_hi),
      .dvm_limit_hi  (dvm_limit_hi),
      .spare_en      (spare_en),
      .spare_base_hi (spare_base_hi),
      .spare_limit_hi(spare_limit_hi),
      .region        (rgn[g])
    );
  end

  logic             r_atc, r_viol;
  logic [OUT_W-1:0] r_addr;
  logic [MT_W-1:0]  r_mtype;

  fpx_resolve #(.PTR_W(PTR_W), .OUT_W(OUT_W), .GRAN_W(GRAN_W),
                .DVM_W(DVM_W), .MT_W(MT_W)) u_res (
    .ptr           (in_ptr),
    .rgn_first     (rgn_first),
    .rgn_last      (rgn_last),
    .wrap          (wrap),
    .mode_host_dflt(mode_host_dflt),
    .dvm_base_hi   (dvm_base_hi),
    .mt_dflt       (mt_dflt),
    .mt_dvm        (mt_dvm),
    .mt_spare      (mt_spare),
    .atc           (r_atc),
    .addr          (r_addr),
    .mtype         (r_mtype),
    .viol          (r_viol)
  );

  fpx_stage #(.OUT_W(OUT_W), .MT_W(MT_W)) u_stg (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .d_atc    (r_atc),
    .d_addr   (r_addr),
    .d_mtype  (r_mtype),
    .d_viol   (r_viol),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .q_atc    (out_atc),
    .q_addr   (out_addr),
    .q_mtype  (out_mtype),
    .q_viol   (out_viol)
  );
endmodule

// File: rtl/fpx_checker.sv
module fpx_checker #(
  parameter int PTR_W = 64,
  parameter int OUT_W = 48,
  parameter int DVM_W = 40,
  parameter int MT_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [PTR_W-1:0] in_ptr,
  input logic             dvm_en,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_atc,
  input logic [OUT_W-1:0] out_addr,
  input logic [MT_W-1:0]  out_mtype,
  input logic             out_viol,
  input fpx_pkg::region_e rgn_first,
  input fpx_pkg::region_e rgn_last,
  input logic             wrap
);
  logic fire, noncanon;
  assign fire     = in_valid && in_ready;
  assign noncanon = !((in_ptr[PTR_W-1:OUT_W-1] == '0) || (&in_ptr[PTR_W-1:OUT_W-1]));

  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_atc)
                                   && $stable(out_mtype) && $stable(out_viol)));

  assert_hole_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && noncanon && !dvm_en) |=> out_viol);

  assert_straddle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ((rgn_first != rgn_last) || wrap)) |=> out_viol);

  assert_dvm_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && rgn_first == fpx_pkg::RG_DVM && rgn_last == fpx_pkg::RG_DVM && !wrap)
      |=> (!out_atc && (out_viol || out_addr[OUT_W-1:DVM_W] == '0)));
endmodule

bind flat_ptr_xlate fpx_checker #(.PTR_W(PTR_W), .OUT_W(OUT_W), .DVM_W(DVM_W), .MT_W(MT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_ptr   (in_ptr),
  .dvm_en   (dvm_en),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_atc  (out_atc),
  .out_addr (out_addr),
  .out_mtype(out_mtype),
  .out_viol (out_viol),
  .rgn_first(rgn_first),
  .rgn_last (rgn_last),
  .wrap     (wrap)
);

// File: tb/flat_ptr_xlate_bench.sv
module flat_ptr_xlate_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [63:0] in_ptr = '0;
  logic [7:0]  in_cnt = '0;
  logic mode_host_dflt = 1'b1;
  logic dvm_en = 1'b1;
  logic [47:0] dvm_base_hi  = 48'h2001_0000_0000;
  logic [47:0] dvm_limit_hi = 48'h2001_00FF_FFFF;
  logic spare_en = 1'b1;
  logic [47:0] spare_base_hi  = 48'h0000_7000_0000;
  logic [47:0] spare_limit_hi = 48'h0000_7000_0FFF;
  logic [1:0] mt_dflt = 2'd0, mt_dvm = 2'd1, mt_spare = 2'd2;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_atc;
  logic [47:0] out_addr;
  logic [1:0] out_mtype;
  logic out_viol;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flat_ptr_xlate u_flat_ptr_xlate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ptr(in_ptr), .in_cnt(in_cnt), .mode_host_dflt(mode_host_dflt),
    .dvm_en(dvm_en), .dvm_base_hi(dvm_base_hi), .dvm_limit_hi(dvm_limit_hi),
    .spare_en(spare_en), .spare_base_hi(spare_base_hi), .spare_limit_hi(spare_limit_hi),
    .mt_dflt(mt_dflt), .mt_dvm(mt_dvm), .mt_spare(mt_spare),
    .out_valid(out_valid), .out_ready(out_ready), .out_atc(out_atc),
    .out_addr(out_addr), .out_mtype(out_mtype), .out_viol(out_viol)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One accepted request; result is sampled one edge later.
  task automatic xfer(input logic [63:0] p, input logic [7:0] c, input logic m);
    @(negedge clk);
    in_ptr = p; in_cnt = c; mode_host_dflt = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_ok(input string tag, input logic atc, input logic [47:0] a,
                           input logic [1:0] mt);
    chk({tag, " valid"}, 64'(out_valid), 64'd1);
    chk({tag, " viol"},  64'(out_viol), 64'd0);
    chk({tag, " atc"},   64'(out_atc), 64'(atc));
    chk({tag, " addr"},  64'(out_addr), 64'(a));
    chk({tag, " mtype"}, 64'(out_mtype), 64'(mt));
  endtask

  task automatic expect_viol(input string tag);
    chk({tag, " valid"}, 64'(out_valid), 64'd1);
    chk({tag, " viol"},  64'(out_viol), 64'd1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R10 out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 out_valid after reset", 64'(out_valid), 64'd0);
    chk("R10 in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_default;
    xfer(64'h0000_1234_5678_9ABC, 8'd3, 1'b1);
    expect_ok("R4 host default", 1'b1, 48'h1234_5678_9ABC, 2'd0);
    xfer(64'h0000_1234_5678_9ABC, 8'd3, 1'b0);
    expect_ok("R4 device default", 1'b0, 48'h1234_5678_9ABC, 2'd0);
  endtask

  task automatic t_canonical;
    xfer(64'hFFFF_8000_0000_0010, 8'd0, 1'b1);
    expect_ok("R2 upper canonical", 1'b1, 48'h8000_0000_0010, 2'd0);
    xfer(64'h0001_0000_0000_0000, 8'd0, 1'b1);
    expect_viol("R2 hole pointer");
    xfer(64'h0000_7FFF_FFFF_FFFC, 8'd7, 1'b1);
    expect_viol("R2 tail in hole");
  endtask

  task automatic t_dvm;
    xfer(64'h2001_0000_0000_0000, 8'd0, 1'b1);
    expect_ok("R1 R3 dvm base", 1'b0, 48'h0, 2'd1);
    xfer(64'h2001_00FF_FFFF_FFFF, 8'd0, 1'b1);
    expect_ok("R1 R7 dvm limit", 1'b0, 48'h00FF_FFFF_FFFF, 2'd1);
    xfer(64'h2001_0100_0000_0000, 8'd0, 1'b1);
    expect_viol("R1 dvm limit+1");
    xfer(64'h2000_FFFF_FFFF_FFFF, 8'd0, 1'b1);
    expect_viol("R1 dvm base-1");
    xfer(64'h2001_0012_3456_7890, 8'd7, 1'b0);
    expect_ok("R3 dvm mid", 1'b0, 48'h0012_3456_7890, 2'd1);
  endtask

  task automatic t_spare;
    xfer(64'h0000_7000_0000_0000, 8'd0, 1'b1);
    expect_ok("R5 R1 spare base", 1'b1, 48'h7000_0000_0000, 2'd2);
    xfer(64'h0000_6FFF_FFFF_FFFF, 8'd0, 1'b1);
    expect_ok("R1 spare base-1", 1'b1, 48'h6FFF_FFFF_FFFF, 2'd0);
    xfer(64'h0000_7000_0FFF_FFF8, 8'd7, 1'b0);
    expect_ok("R5 spare top device mode", 1'b0, 48'h7000_0FFF_FFF8, 2'd2);
  endtask

  task automatic t_straddle;
    xfer(64'h0000_7000_0FFF_FFF8, 8'd15, 1'b1);
    expect_viol("R6 spare to default");
    xfer(64'hFFFF_FFFF_FFFF_FFFC, 8'd7, 1'b1);
    expect_viol("R6 wrap past top");
    xfer(64'hFFFF_FFFF_FFFF_FFF8, 8'd7, 1'b1);
    expect_ok("R6 ends at top", 1'b1, 48'hFFFF_FFFF_FFF8, 2'd0);
  endtask

  task automatic t_dvm_range;
    @(negedge clk);
    dvm_limit_hi = 48'h2001_01FF_FFFF;
    xfer(64'h2001_0100_0000_0000, 8'd0, 1'b1);
    expect_viol("R7 offset 2^40");
    xfer(64'h2001_00FF_FFFF_FFF0, 8'd0, 1'b1);
    expect_ok("R7 offset below 2^40", 1'b0, 48'h00FF_FFFF_FFF0, 2'd1);
    dvm_limit_hi = 48'h2001_00FF_FFFF;
  endtask

  task automatic t_disable;
    @(negedge clk);
    dvm_en = 1'b0;
    xfer(64'h2001_0000_0000_0000, 8'd0, 1'b1);
    expect_viol("R8 dvm disabled");
    dvm_en = 1'b1;
    spare_en = 1'b0;
    xfer(64'h0000_7000_0000_0000, 8'd0, 1'b1);
    expect_ok("R8 spare disabled", 1'b1, 48'h7000_0000_0000, 2'd0);
    spare_en = 1'b1;
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    in_ptr = 64'h0000_0000_0000_1000; in_cnt = 8'd0; mode_host_dflt = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    expect_ok("R9 first held", 1'b1, 48'h1000, 2'd0);
    chk("R9 in_ready low in stall", 64'(in_ready), 64'd0);
    in_ptr = 64'h0000_0000_0000_2000;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      expect_ok("R9 stall hold", 1'b1, 48'h1000, 2'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_ok("R9 next after release", 1'b1, 48'h2000, 2'd0);
    @(negedge clk);
    chk("R9 drains", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_default();
    t_canonical();
    t_dvm();
    t_spare();
    t_straddle();
    t_dvm_range();
    t_disable();
    t_backpressure();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule